// File: doc/BRIEF.md
# Rational Resize Phase Sequence Generator

This block turns a resize ratio into the ordered list of per-phase entries that a resize coefficient table is loaded with. The ratio is given as an output pixel count `num` and an input pixel count `den`. The block first reduces the ratio by its greatest common divisor. It then picks one of three stepping rules: downscale, integer upscale or fractional upscale. After a start-of-table marker word it emits one entry per output phase. Each entry carries a weight between 0 and 512, where 512 means all of the nearer source pixel. It also carries a source-advance offset, which is the number of source pixels to step past after this phase.

A controller pulses `start` with a ratio on the inputs. The block stays busy while it reduces the ratio and steps through the phases. Entries leave through a valid/ready stream. The block pulses `done` after the last entry has been accepted. It pulses `err`, and emits nothing, when it cannot build the table. A single shared restoring divider produces every quotient and remainder, one bit per cycle.

Top module: `rsz_phase_gen`

## Requirements
- R1: The first word of every table is a marker: `out_marker`=1, `out_weight` all ones (10'h3FF) and `out_offset` all ones. No marker is sent when no table is built.
- R2: After reduction to n/d the block emits exactly n entries after the marker. The downscale rule is used when d>n. The integer upscale rule is used when d==1. The fractional upscale rule is used in every other case.
- R3: Fractional upscale: the accumulator starts at 0. For each entry, weight = 512 - floor(512*acc/n). The block then adds d to acc. If acc>=n, offset=1 and n is subtracted from acc; otherwise offset=0.
- R4: Downscale: the accumulator starts at d. For each entry, acc = n + (acc-n) mod 2n and weight = 512 - floor(512*(acc-n)/2n). The block then adds 2d to acc, and offset = floor((acc-n)/2n).
- R5: Integer upscale: every entry has weight 512 and `out_nearest`=1. Offset is 1 on the last entry and 0 on all the others. `out_nearest` is 0 on every other kind of entry.
- R6: num and den are divided by their greatest common divisor. If the reduced num is above 31, `err` pulses and no word is emitted.
- R7: A ratio that reduces to 1:1 emits no words and pulses `done` once.
- R8: If num or den is zero, `err` pulses and no word is emitted.
- R9: A word whose valid is not accepted holds all of its fields stable until `out_ready` is high. A word transfers on a rising edge where both `out_valid` and `out_ready` are high.
- R10: A `start` pulse that arrives while `busy` is high is ignored. The running table continues unchanged.
- R11: `busy` is high from the cycle after an accepted start until the cycle of `done` or `err`. `done` and `err` are single-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a table for the ratio on num_in/den_in |
| num_in | input | W | Output pixel count of the ratio |
| den_in | input | W | Input pixel count of the ratio |
| busy | output | 1 | A table is being computed or emitted |
| done | output | 1 | One-cycle pulse: table finished, or 1:1 bypass |
| err | output | 1 | One-cycle pulse: ratio rejected |
| out_valid | output | 1 | Word on the output fields is valid |
| out_ready | input | 1 | Consumer accepts the word |
| out_marker | output | 1 | Word is the start-of-table marker |
| out_nearest | output | 1 | Entry forces nearest-neighbour sampling |
| out_weight | output | 10 | Weight of the nearer pixel, 0..512 |
| out_offset | output | W | Source pixels to advance after this phase |

## Verification
The hardest condition to reach is a `start` pulse that lands while a table is in flight. The same applies to a word stalled at the exact moment the divider would otherwise move on. To reach both, one directed case holds `out_ready` low on a repeating pattern while the entries stream out, and a second case pulses `start` with a different ratio in the middle of a run. Ratios such as 62/4 and 64/2 reduce to just below and just above the 31-entry limit, so the reduction and the reject check are exercised at their boundary.

// File: rtl/rsz_phase_gen.sv
module rsz_phase_gen #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] num_in,
  input  logic [W-1:0] den_in,
  output logic         busy,
  output logic         done,
  output logic         err,
  output logic         out_valid,
  input  logic         out_ready,
  output logic         out_marker,
  output logic         out_nearest,
  output logic [9:0]   out_weight,
  output logic [W-1:0] out_offset
);
  localparam int DW = (W + 4 > 16) ? W + 4 : 16;
  localparam int CW = $clog2(DW);
  localparam int MAXN = 31;

  localparam logic [3:0] S_IDLE = 4'd0, S_GCD = 4'd1, S_DIV = 4'd2, S_RN = 4'd3,
                         S_RD = 4'd4, S_EMIT = 4'd5, S_PREP = 4'd6, S_FW = 4'd7,
                         S_DM = 4'd8, S_DW = 4'd9, S_DO = 4'd10;
  localparam logic [1:0] M_INT = 2'd0, M_FRAC = 2'd1, M_DOWN = 2'd2;

  logic [3:0]    st, dv_ret, ld_ret;
  logic [1:0]    mode;
  logic [W-1:0]  num_l, den_l, ga, gb, n, d;
  logic [DW-1:0] acc, dv_rem, dv_quo, dv_den, ld_x, ld_y, n2, dd2;
  logic [CW-1:0] dv_cnt;
  logic [4:0]    idx;
  logic          ld;
  logic [DW:0]   dv_sh;
  logic          dv_ge;
  logic          last_idx;

  assign busy     = (st != S_IDLE);
  assign n2       = DW'({n, 1'b0});
  assign dd2      = DW'({d, 1'b0});
  assign dv_sh    = {dv_rem, dv_quo[DW-1]};
  assign dv_ge    = dv_sh >= {1'b0, dv_den};
  assign last_idx = (W'(idx) == n - W'(1));

  always_comb begin
    ld = 1'b0; ld_x = '0; ld_y = DW'(1); ld_ret = S_IDLE;
    case (st)
      S_GCD: if (ga == gb) begin ld = 1'b1; ld_x = DW'(num_l); ld_y = DW'(ga); ld_ret = S_RN; end
      S_RN:  begin ld = 1'b1; ld_x = DW'(den_l); ld_y = DW'(ga); ld_ret = S_RD; end
      S_PREP:
        if (mode == M_FRAC) begin
          ld = 1'b1; ld_x = acc << 9; ld_y = DW'(n); ld_ret = S_FW;
        end else if (mode == M_DOWN) begin
          ld = 1'b1; ld_x = acc - DW'(n); ld_y = n2; ld_ret = S_DM;
        end
      S_DM:  begin ld = 1'b1; ld_x = dv_rem << 9; ld_y = n2; ld_ret = S_DW; end
      S_DW:  begin ld = 1'b1; ld_x = acc + dd2 - DW'(n); ld_y = n2; ld_ret = S_DO; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; dv_ret <= S_IDLE; mode <= M_INT;
      num_l <= '0; den_l <= '0; ga <= '0; gb <= '0; n <= '0; d <= '0;
      acc <= '0; dv_rem <= '0; dv_quo <= '0; dv_den <= '0; dv_cnt <= '0; idx <= '0;
      done <= 1'b0; err <= 1'b0;
      out_valid <= 1'b0; out_marker <= 1'b0; out_nearest <= 1'b0;
      out_weight <= '0; out_offset <= '0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      if (ld) begin
        dv_quo <= ld_x; dv_den <= ld_y; dv_rem <= '0; dv_cnt <= '0;
        dv_ret <= ld_ret; st <= S_DIV;
      end
      case (st)
        S_IDLE:
          if (start) begin
            if (num_in == '0 || den_in == '0) err <= 1'b1;
            else begin
              num_l <= num_in; den_l <= den_in; ga <= num_in; gb <= den_in; st <= S_GCD;
            end
          end
        S_GCD:
          if (ga > gb) ga <= ga - gb;
          else if (gb > ga) gb <= gb - ga;
        S_DIV: begin
          dv_rem <= dv_ge ? DW'(dv_sh - {1'b0, dv_den}) : dv_sh[DW-1:0];
          dv_quo <= {dv_quo[DW-2:0], dv_ge};
          dv_cnt <= dv_cnt + CW'(1);
          if (dv_cnt == CW'(DW - 1)) st <= dv_ret;
        end
        S_RN: n <= dv_quo[W-1:0];
        S_RD: begin
          if (n > W'(MAXN)) begin
            err <= 1'b1; st <= S_IDLE;
          end else if (n == W'(1) && dv_quo == DW'(1)) begin
            done <= 1'b1; st <= S_IDLE;
          end else begin
            d <= dv_quo[W-1:0];
            idx <= '0;
            if (dv_quo > DW'(n)) begin mode <= M_DOWN; acc <= dv_quo; end
            else begin mode <= (dv_quo == DW'(1)) ? M_INT : M_FRAC; acc <= '0; end
            out_valid <= 1'b1; out_marker <= 1'b1; out_nearest <= 1'b0;
            out_weight <= '1; out_offset <= '1;
            st <= S_EMIT;
          end
        end
        S_PREP:
          if (mode == M_INT) begin
            out_valid <= 1'b1; out_marker <= 1'b0; out_nearest <= 1'b1;
            out_weight <= 10'd512; out_offset <= W'(last_idx);
            st <= S_EMIT;
          end
        S_FW: begin
          out_weight <= 10'(10'd512 - dv_quo[9:0]);
          out_marker <= 1'b0; out_nearest <= 1'b0; out_valid <= 1'b1;
          if (acc + DW'(d) >= DW'(n)) begin
            acc <= acc + DW'(d) - DW'(n); out_offset <= W'(1);
          end else begin
            acc <= acc + DW'(d); out_offset <= '0;
          end
          st <= S_EMIT;
        end
        S_DM: acc <= DW'(n) + dv_rem;
        S_DW: begin
          out_weight <= 10'(10'd512 - dv_quo[9:0]);
          acc <= acc + dd2;
        end
        S_DO: begin
          out_offset <= dv_quo[W-1:0];
          out_marker <= 1'b0; out_nearest <= 1'b0; out_valid <= 1'b1;
          st <= S_EMIT;
        end
        S_EMIT:
          if (out_ready) begin
            out_valid <= 1'b0;
            if (out_marker) st <= S_PREP;
            else if (last_idx) begin done <= 1'b1; st <= S_IDLE; end
            else begin idx <= idx + 5'd1; st <= S_PREP; end
          end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_weight) && $stable(out_offset)
                                && $stable(out_marker) && $stable(out_nearest));
  a_r11_pulses_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, err}));
  a_r11_idle_after_end: assert property (@(posedge clk) disable iff (!rst_n)
    done || err |-> !busy && !out_valid);
  a_r1_marker_ones: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_marker |-> out_weight == 10'h3FF && out_offset == '1);
  a_r5_nearest_full: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_nearest |-> out_weight == 10'd512 && out_offset <= W'(1));
  a_r3_weight_range: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_marker |-> out_weight <= 10'd512);
  a_r10_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_marker |-> busy);
endmodule

// File: tb/rsz_phase_gen_tb.sv
module rsz_phase_gen_tb;
  localparam int W = 12;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, out_ready = 1'b0;
  logic [W-1:0] num_in = '0, den_in = '0;
  logic busy, done, err, out_valid, out_marker, out_nearest;
  logic [9:0] out_weight;
  logic [W-1:0] out_offset;
  int total = 0, bad = 0;
  int ew[32], eo[32], en[32];
  int ecnt;

  always #5 clk = ~clk;

  rsz_phase_gen #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .num_in(num_in), .den_in(den_in),
    .busy(busy), .done(done), .err(err), .out_valid(out_valid), .out_ready(out_ready),
    .out_marker(out_marker), .out_nearest(out_nearest),
    .out_weight(out_weight), .out_offset(out_offset));

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // model from the requirements; returns 0 ok, 1 error, 2 bypass
  function automatic int model(input int num, input int den);
    int a, b, n, d, acc;
    if (num == 0 || den == 0) return 1;
    a = num; b = den;
    while (a != b) if (a > b) a -= b; else b -= a;
    n = num / a; d = den / a;
    if (n > 31) return 1;
    if (n == 1 && d == 1) return 2;
    ecnt = n;
    if (d > n) begin
      acc = d;
      for (int i = 0; i < n; i++) begin
        acc = n + (acc - n) % (2 * n);
        ew[i] = 512 - 512 * (acc - n) / (2 * n);
        acc += 2 * d;
        eo[i] = (acc - n) / (2 * n); en[i] = 0;
      end
    end else if (d == 1) begin
      for (int i = 0; i < n; i++) begin ew[i] = 512; eo[i] = (i == n - 1); en[i] = 1; end
    end else begin
      acc = 0;
      for (int i = 0; i < n; i++) begin
        ew[i] = 512 - 512 * acc / n;
        acc += d;
        eo[i] = (acc >= n) ? 1 : 0;
        if (acc >= n) acc -= n;
        en[i] = 0;
      end
    end
    return 0;
  endfunction

  // stall: hold ready low on a pattern; poke: pulse start again mid-run
  task automatic run_case(input string req, input int num, input int den,
                          input bit stall, input bit poke);
    int kind, got, cyc, words;
    bit fin, saw_done, saw_err, held;
    logic [9:0] hw; logic [W-1:0] ho; logic hm;
    kind = model(num, den);
    @(negedge clk);
    num_in = W'(num); den_in = W'(den); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R11 busy after start", int'(busy) | int'(err), 1);
    got = 0; words = 0; cyc = 0; fin = 0; saw_done = 0; saw_err = 0; held = 0;
    while (!fin && cyc < 20000) begin
      if (held) begin
        chk("R9 weight held", out_weight, hw);
        chk("R9 offset held", out_offset, ho);
        chk("R9 marker held", out_marker, hm);
        held = 0;
      end
      if (done) begin saw_done = 1; fin = 1; end
      if (err) begin saw_err = 1; fin = 1; end
      if (!fin) begin
        if (poke && cyc == 7) begin num_in = 5; den_in = 1; start = 1'b1; end
        else start = 1'b0;
        out_ready = stall ? (cyc % 3 != 0) : 1'b1;
        if (out_valid && !out_ready) begin held = 1; hw = out_weight; ho = out_offset; hm = out_marker; end
        if (out_valid && out_ready) begin
          if (words == 0) begin
            chk("R1 marker flag", out_marker, 1);
            chk("R1 marker weight", out_weight, 1023);
            chk("R1 marker offset", out_offset, (1 << W) - 1);
          end else if (got < 32) begin
            chk({req, " weight"}, out_weight, ew[got]);
            chk({req, " offset"}, out_offset, eo[got]);
            chk("R5 nearest flag", out_nearest, en[got]);
            chk("R1 marker only first", out_marker, 0);
            got++;
          end
          words++;
        end
        cyc++;
        @(negedge clk);
      end
    end
    start = 1'b0; out_ready = 1'b0;
    if (cyc >= 20000) chk({req, " timeout"}, 1, 0);
    if (kind == 0) begin
      chk("R2 entry count", got, ecnt);
      chk("R11 done pulse", saw_done, 1);
    end else if (kind == 1) begin
      chk("R6 R8 err pulse", saw_err, 1);
      chk("R6 R8 no words", words, 0);
    end else begin
      chk("R7 bypass done", saw_done, 1);
      chk("R7 bypass no words", words, 0);
    end
    @(negedge clk);
    chk("R11 idle after end", busy, 0);
    chk("R11 pulse single", int'(done) + int'(err), 0);
  endtask

  task automatic t_reset();
    chk("R11 reset busy", busy, 0);
    chk("R9 reset valid", out_valid, 0);
    chk("R11 reset done", done, 0);
    chk("R11 reset err", err, 0);
  endtask

  task automatic t_frac();     run_case("R3 frac 3/2", 3, 2, 0, 0);
                               run_case("R3 frac 7/5", 7, 5, 1, 0);
                               run_case("R3 frac 31/30", 31, 30, 0, 0); endtask
  task automatic t_down();     run_case("R4 down 2/5", 2, 5, 0, 0);
                               run_case("R4 down 5/17", 5, 17, 1, 0);
                               run_case("R4 down 1/4095", 1, 4095, 0, 0); endtask
  task automatic t_int();      run_case("R5 int 4/1", 4, 1, 1, 0);
                               run_case("R5 int 2/1", 2, 1, 0, 0); endtask
  task automatic t_reduce();   run_case("R6 reduce 62/4", 62, 4, 0, 0);
                               run_case("R6 reject 64/2", 64, 2, 0, 0);
                               run_case("R6 reject 33/1", 33, 1, 0, 0);
                               run_case("R2 reduce 12/8", 12, 8, 0, 0); endtask
  task automatic t_bypass();   run_case("R7 bypass 6/6", 6, 6, 0, 0); endtask
  task automatic t_zero();     run_case("R8 zero num", 0, 5, 0, 0);
                               run_case("R8 zero den", 5, 0, 0, 0); endtask
  task automatic t_poke();     run_case("R10 poke 7/3", 7, 3, 1, 1); endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_frac();
    t_down();
    t_int();
    t_reduce();
    t_bypass();
    t_zero();
    t_poke();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule